// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one SDRAM burst. A start pulse loads a starting column, a burst length code and an ordering mode. The block then presents one column per clock with a valid flag, and a last flag on the final beat. Both a memory model and a controller can use the same sequence to learn which word each data beat refers to.

In the fixed-length modes, only the low column bits that span the burst move. Sequential ordering steps those bits upward and wraps them within the burst. Interleaved ordering XORs them with the beat number. No carry ever reaches the bits above the burst.

A full-page burst walks every column of the row, wraps from the top column to zero, and continues until it is stopped. A stop request or a new start ends a burst early. A new start begins its own burst at once from its own column.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and until the first start after reset, `valid_o` and `last_o` are 0.
- R2: On the clock after a cycle with `start_i` high, `valid_o` is 1 and `col_o` equals the `start_col_i` sampled with that start (beat 0).
- R3: The length code on `len_i` maps as follows: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives a full page. Codes 3'b100, 3'b101 and 3'b110 give 1 beat. A fixed burst of N beats, left alone, shows exactly N consecutive valid beats and then `valid_o` drops.
- R4: With `interleave_i` = 0 and a burst of N beats (N = 2, 4 or 8), beat k carries low log2(N) bits equal to (start low bits + k) mod N. All higher column bits equal those of the start column.
- R5: With `interleave_i` = 1 and a burst of N beats, beat k carries low log2(N) bits equal to (start low bits XOR k). All higher column bits are unchanged.
- R6: In a full-page burst, each beat's column is the previous column plus 1 modulo 2^COL_W (255 is followed by 0). The burst continues until a stop or a new start. `interleave_i` has no effect in full-page mode.
- R7: `last_o` is 1 only on the final beat of a fixed-length burst. It is never 1 during a full-page burst or while `valid_o` is 0.
- R8: `stop_i` high on a cycle with a valid beat and no start makes `valid_o` 0 on the next clock. `stop_i` while idle has no effect.
- R9: `start_i` during a burst ends that burst. The next clock shows beat 0 of the new burst. If `start_i` and `stop_i` are high together, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new burst with the values on the inputs below |
| start_col_i | input | COL_W | First column of the burst |
| len_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = XOR ordering, 0 = sequential ordering |
| stop_i | input | 1 | End the running burst after the current beat |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The bench starts fixed-length bursts from columns whose low bits sit near the wrap point, for example a 4-beat burst from column 0x2E. A design that let the carry escape would move the upper bits, and one that mixed up the two orderings would produce the wrong beat order. Full-page bursts are started just below column 255, which catches a design that saturates, stops at the row end, or raises `last_o`. Starts that land mid-burst, and starts that coincide with a stop, expose a design that finishes the old burst or lets the stop win. The reserved length codes and a stop issued while idle catch a design that emits phantom beats.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic [2:0] {
    BLEN_1    = 3'b000,
    BLEN_2    = 3'b001,
    BLEN_4    = 3'b010,
    BLEN_8    = 3'b011,
    BLEN_PAGE = 3'b111
  } blen_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       len_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o
);
  always_comb begin
    mask_o = '0;
    page_o = 1'b0;
    case (blen_e'(len_i))
      BLEN_2:    mask_o = COL_W'(1);
      BLEN_4:    mask_o = COL_W'(3);
      BLEN_8:    mask_o = COL_W'(7);
      BLEN_PAGE: begin
        mask_o = '1;
        page_o = 1'b1;
      end
      default:   mask_o = '0;
    endcase
  end
endmodule

// File: rtl/burst_beat_addr.sv
module burst_beat_addr #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             xor_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum_w;
  logic [COL_W-1:0] mix_w;

  always_comb begin
    sum_w = base_i + beat_i;
    mix_w = base_i ^ beat_i;
    col_o = (base_i & ~mask_i) | ((xor_i ? mix_w : sum_w) & mask_i);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_i,
  input  logic             interleave_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  logic [COL_W-1:0] dec_mask_w;
  logic             dec_page_w;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .len_i  (len_i),
    .mask_o (dec_mask_w),
    .page_o (dec_page_w)
  );

  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             page_q, page_d;
  logic             xor_q,  xor_d;
  logic             act_q,  act_d;
  logic             load_en, step_en, act_en;
  logic             final_w;

  assign final_w = act_q & ~page_q & (beat_q == mask_q);

  always_comb begin
    load_en = start_i;
    step_en = ~start_i & act_q & ~stop_i & ~final_w;
    act_en  = start_i | act_q;
    base_d  = start_col_i;
    mask_d  = dec_mask_w;
    page_d  = dec_page_w;
    xor_d   = interleave_i & ~dec_page_w;
    beat_d  = start_i ? '0 : beat_q + 1'b1;
    act_d   = start_i | (act_q & ~stop_i & ~final_w);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      base_q <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      xor_q  <= 1'b0;
    end else if (load_en) begin
      base_q <= base_d;
      mask_q <= mask_d;
      page_q <= page_d;
      xor_q  <= xor_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)                beat_q <= '0;
    else if (load_en || step_en)   beat_q <= beat_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   act_q <= 1'b0;
    else if (act_en)  act_q <= act_d;
  end

  burst_beat_addr #(.COL_W(COL_W)) u_addr (
    .base_i (base_q),
    .beat_i (beat_q),
    .mask_i (mask_q),
    .xor_i  (xor_q),
    .col_o  (col_o)
  );

  assign valid_o = act_q;
  assign last_o  = final_w;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic [2:0] len_cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_cap_q <= 3'b000;
    else if (start_i) len_cap_q <= len_i;
  end

  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R2
  start_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o && col_o == $past(start_col_i));

  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && stop_i && !start_i |=> !valid_o);

  // R3
  after_last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && last_o && !start_i |=> !valid_o);

  // R1
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o && !start_i |=> !valid_o);

  // R6
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !start_i && !stop_i && len_cap_q == 3'b111
    |=> valid_o && col_o == COL_W'($past(col_o) + 1'b1));

  // R4
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o && !start_i && !stop_i && len_cap_q == 3'b011
    |=> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .len_i       (len_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       len_i;
  logic             interleave_i;
  logic             stop_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_i(len_i), .interleave_i(interleave_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  // behavioural reference model
  bit m_act  = 1'b0;
  bit m_page = 1'b0;
  bit m_xor  = 1'b0;
  int m_base = 0;
  int m_k    = 0;
  int m_n    = 1;

  function automatic int beats_of(input logic [2:0] code);
    case (code)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_act = 1'b0;
    else if (start_i) begin
      m_act  = 1'b1;
      m_base = int'(start_col_i);
      m_k    = 0;
      m_page = (len_i == 3'b111);
      m_n    = m_page ? 256 : beats_of(len_i);
      m_xor  = interleave_i && !m_page;
    end else if (m_act) begin
      if (stop_i) m_act = 1'b0;
      else if (!m_page && m_k == m_n - 1) m_act = 1'b0;
      else m_k = (m_k + 1) % 256;
    end
  end

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int lo, ecol;
      bit elast;
      check_bit("R1 R3 R8 valid_o", valid_o, m_act);
      if (m_act) begin
        if (m_page) ecol = (m_base + m_k) % 256;
        else begin
          lo = m_xor ? ((m_base % m_n) ^ m_k) : (((m_base % m_n) + m_k) % m_n);
          ecol = (m_base - (m_base % m_n)) + lo;
        end
        elast = !m_page && (m_k == m_n - 1);
        n_cmp++;
        if (col_o !== COL_W'(ecol)) begin
          n_bad++;
          $display("FAIL %s col_o at %0t: actual=%0h expected=%0h",
                   m_page ? "R6" : (m_xor ? "R5" : "R4"), $time, col_o, ecol);
        end
        check_bit("R7 last_o", last_o, elast);
      end else begin
        check_bit("R7 last_o idle", last_o, 1'b0);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input int col, input logic [2:0] code, input logic il);
    start_i      = 1'b1;
    start_col_i  = COL_W'(col);
    len_i        = code;
    interleave_i = il;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    n_bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    start_col_i = '0; len_i = 3'b000; interleave_i = 1'b0;
    idle(3);
    // R1: reset state at the ports
    check_bit("R1 valid_o in reset", valid_o, 1'b0);
    check_bit("R1 last_o in reset", last_o, 1'b0);
    rst_n = 1'b1;
    idle(4);
    // R2 R3 R4 R5: every length in both orderings from a mid-burst column
    for (int m = 0; m < 2; m++) begin
      go(8'h2E, 3'b000, m[0]); idle(3);
      go(8'h2E, 3'b001, m[0]); idle(3);
      go(8'h2E, 3'b010, m[0]); idle(5);
      go(8'h2E, 3'b011, m[0]); idle(9);
      go(8'hF5, 3'b011, m[0]); idle(9);
    end
    // R3: reserved codes act as length 1
    go(8'h13, 3'b100, 1'b0); idle(2);
    go(8'h13, 3'b101, 1'b1); idle(2);
    go(8'h13, 3'b110, 1'b0); idle(2);
    // R6: full page wraps 255 -> 0, interleave ignored, then stopped
    go(8'hFC, 3'b111, 1'b1); idle(9);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0; idle(3);
    // R8: stop mid burst, then stop while idle
    go(8'h40, 3'b011, 1'b0); idle(2);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0; idle(3);
    stop_i = 1'b1; idle(2); stop_i = 1'b0; idle(2);
    // R9: start truncates; start wins over stop
    go(8'h80, 3'b011, 1'b1); idle(2);
    go(8'h95, 3'b010, 1'b0); idle(1);
    stop_i = 1'b1; go(8'hA1, 3'b001, 1'b1); stop_i = 1'b0; idle(3);
    go(8'h07, 3'b010, 1'b1); go(8'h09, 3'b011, 1'b0); idle(10);
    done = 1'b1;
    summary();
  end
endmodule